// File: doc/BRIEF.md
# Run-Time Programmable AND-OR Logic Array

This block computes a set of Boolean functions of a wide input vector in two levels of logic, in sum-of-products form. The first level, the AND plane, forms a pool of product terms. Each term is built from any subset of the inputs, and each input in that subset is taken either as is or inverted. The second level, the OR plane, gives each output the OR of a chosen subset of the pool. A term in the pool is a general product, not a minterm. For one input vector, zero, one or many terms can be true at once, and a single term can feed as many outputs as need it. With the default parameters, 16 inputs feed 48 shared terms and 8 outputs, so the array realises 8 functions of 16 variables. The only limit is that all outputs together use at most 48 distinct terms.

Both planes are held in configuration registers and can be rewritten while the chip runs, through a simple write port with an address. The same address selects a row for combinational readback. The data path is purely combinational from the inputs and the current configuration to the outputs. A mode input switches the OR plane to a fixed layout. In that layout each output owns its own group of consecutive terms, while the AND plane stays programmable. The stored OR-plane settings are kept, and they take effect again when the mode input returns to shared mode.

Top module: `pla_core`

## Requirements
- R1: After reset, every AND-plane row and every OR-plane row reads back as zero, and in shared mode every output is 0.
- R2: A write with cfg_addr in 0..47 stores cfg_wdata[31:0] as the AND row of term cfg_addr on the next rising clock edge. Reading that address returns the row in bits [31:0], with bits [47:32] as zero. Without a write, the readback is stable.
- R3: A write with cfg_addr in 48..55 stores cfg_wdata[47:0] as the OR row of output cfg_addr-48. Bit t of that row connects term t to the output, and the row reads back unchanged.
- R4: In an AND row, bits [2i+1:2i] hold the code for input i: 00 leaves the input out, 01 uses the input true, 10 uses it complemented, and 11 forces the term to 0.
- R5: A term whose codes are all 00 is 1. An output whose OR row is all zero is 0 in shared mode.
- R6: When pal_mode is 0, dout[k] is the OR over all terms t with OR-row bit t set. One term may feed several outputs.
- R7: When pal_mode is 1, dout[k] is the OR of terms 6k through 6k+5. OR-row contents and OR-row writes have no effect on dout, but the rows are still stored and read back.
- R8: Writes to addresses 56..63 change nothing, and reads of those addresses return zero.
- R9: dout follows din and pal_mode combinationally, within the same cycle, with no clock edge needed.
- R10: With a=din[0], b=din[1], c=din[2] and d=din[3], programming six shared terms gives dout[0]=a'bd+abd+ab'c'+b'c, dout[1]=c+a'bd and dout[2]=bc+ab'c'+abd for all 16 values of a, b, c and d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset that clears both planes |
| cfg_we | input | 1 | Write enable for the configuration row at cfg_addr |
| cfg_addr | input | 6 | Row address: AND rows 0..47, OR rows 48..55 |
| cfg_wdata | input | 48 | Row data to write |
| cfg_rdata | output | 48 | Combinational readback of the row at cfg_addr |
| pal_mode | input | 1 | 1 selects the fixed OR plane with six terms per output |
| din | input | 16 | Data inputs to the AND plane |
| dout | output | 8 | Function outputs |

## Verification
On every cycle, the assertions check four things. A write lands in the addressed row and reads back masked to that row's width. An unmapped address reads as zero. Readback and outputs stay still when neither inputs nor configuration move. In fixed-OR mode, a write to an OR row cannot disturb the outputs. The actual Boolean values of the outputs can only be shown by the bench's scenarios: the literal codes including the forcing code, the empty-term and empty-output defaults, the three shared-term example functions swept over all sixteen input values, and randomly programmed planes compared against a reference model in both modes.

// File: rtl/pla_pkg.sv
package pla_pkg;

   typedef enum logic [1:0] {
      LIT_DC   = 2'b00,
      LIT_POS  = 2'b01,
      LIT_NEG  = 2'b10,
      LIT_KILL = 2'b11
   } lit_e;

   function automatic logic lit_pass(input logic [1:0] code, input logic bit_in);
      logic ok;
      case (lit_e'(code))
         LIT_DC:  ok = 1'b1;
         LIT_POS: ok = bit_in;
         LIT_NEG: ok = ~bit_in;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pla_cfg_dec.sv
module pla_cfg_dec #(
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8,
   parameter int AW     = 6,
   parameter int IW     = 6,
   parameter int OW     = 3
) (
   input  logic          we,
   input  logic [AW-1:0] addr,
   output logic          and_sel,
   output logic          or_sel,
   output logic          and_we,
   output logic          or_we,
   output logic [IW-1:0] and_idx,
   output logic [OW-1:0] or_idx
);
   localparam logic [AW-1:0] OR_BASE = AW'(N_TERM);
   localparam logic [AW:0]   ROW_END = (AW+1)'(N_TERM + N_OUT);

   logic [AW-1:0] or_off;

   assign and_sel = (addr < OR_BASE);
   assign or_sel  = !and_sel && ({1'b0, addr} < ROW_END);
   assign and_we  = we && and_sel;
   assign or_we   = we && or_sel;
   assign and_idx = addr[IW-1:0];
   assign or_off  = addr - OR_BASE;
   assign or_idx  = or_off[OW-1:0];

   generate
      if (AW > OW) begin : g_spare
         logic [AW-OW-1:0] unused_off_hi;
         assign unused_off_hi = or_off[AW-1:OW];
      end
   endgenerate
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48,
   parameter int IW     = 6,
   localparam int RW    = 2 * N_IN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     idx,
   input  logic [RW-1:0]     wr_data,
   output logic [RW-1:0]     rd_data,
   input  logic [N_IN-1:0]   din,
   output logic [N_TERM-1:0] term_hit
);
   logic [RW-1:0] row_q [N_TERM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < N_TERM; t++) row_q[t] <= '0;
      end else if (wr_en) begin
         for (int t = 0; t < N_TERM; t++)
            if (idx == IW'(t)) row_q[t] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int t = 0; t < N_TERM; t++)
         if (idx == IW'(t)) rd_data = row_q[t];
   end

   generate
      for (genvar t = 0; t < N_TERM; t++) begin : g_term
         logic [N_IN-1:0] lit_ok;
         for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign lit_ok[i] = lit_pass(row_q[t][2*i +: 2], din[i]);
         end
         assign term_hit[t] = &lit_ok;
      end
   endgenerate
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8,
   parameter int OW     = 3,
   parameter bit PAL_EN = 1'b1,
   localparam int GROUP = N_TERM / N_OUT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OW-1:0]     idx,
   input  logic [N_TERM-1:0] wr_data,
   output logic [N_TERM-1:0] rd_data,
   input  logic [N_TERM-1:0] term_hit,
   input  logic              pal_mode,
   output logic [N_OUT-1:0]  dout
);
   logic [N_TERM-1:0] mask_q [N_OUT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_OUT; k++) mask_q[k] <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < N_OUT; k++)
            if (idx == OW'(k)) mask_q[k] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N_OUT; k++)
         if (idx == OW'(k)) rd_data = mask_q[k];
   end

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_out
         logic shared_or;
         assign shared_or = |(term_hit & mask_q[k]);
         if (PAL_EN) begin : g_fixed
            logic fixed_or;
            assign fixed_or = |term_hit[GROUP*k +: GROUP];
            assign dout[k]  = pal_mode ? fixed_or : shared_or;
         end else begin : g_prog
            assign dout[k] = shared_or;
         end
      end
      if (!PAL_EN) begin : g_nopal
         logic unused_pal;
         assign unused_pal = pal_mode;
      end
   endgenerate
endmodule

// File: rtl/pla_core.sv
module pla_core
   import pla_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8,
   parameter bit PAL_EN = 1'b1,
   localparam int N_ROWS = N_TERM + N_OUT,
   localparam int AW     = idx_width(N_ROWS),
   localparam int DW     = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [DW-1:0]   cfg_wdata,
   output logic [DW-1:0]   cfg_rdata,
   input  logic            pal_mode,
   input  logic [N_IN-1:0] din,
   output logic [N_OUT-1:0] dout
);
   localparam int IW = idx_width(N_TERM);
   localparam int OW = idx_width(N_OUT);
   localparam int RW = 2 * N_IN;

   generate
      if (N_IN < 1 || N_TERM < 2 || N_OUT < 2) begin : g_bad_size
         $error("pla_core: N_IN >= 1, N_TERM >= 2 and N_OUT >= 2 required");
      end
      if (PAL_EN && (N_TERM % N_OUT != 0)) begin : g_bad_group
         $error("pla_core: fixed OR mode needs N_TERM divisible by N_OUT");
      end
   endgenerate

   logic              and_sel, or_sel, and_we, or_we;
   logic [IW-1:0]     and_idx;
   logic [OW-1:0]     or_idx;
   logic [RW-1:0]     and_rd;
   logic [N_TERM-1:0] or_rd;
   logic [N_TERM-1:0] term_hit;

   pla_cfg_dec #(
      .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .IW(IW), .OW(OW)
   ) u_dec (
      .we(cfg_we), .addr(cfg_addr),
      .and_sel(and_sel), .or_sel(or_sel),
      .and_we(and_we), .or_we(or_we),
      .and_idx(and_idx), .or_idx(or_idx)
   );

   pla_and_plane #(
      .N_IN(N_IN), .N_TERM(N_TERM), .IW(IW)
   ) u_and (
      .clk(clk), .rst_n(rst_n),
      .wr_en(and_we), .idx(and_idx), .wr_data(cfg_wdata[RW-1:0]),
      .rd_data(and_rd), .din(din), .term_hit(term_hit)
   );

   pla_or_plane #(
      .N_TERM(N_TERM), .N_OUT(N_OUT), .OW(OW), .PAL_EN(PAL_EN)
   ) u_or (
      .clk(clk), .rst_n(rst_n),
      .wr_en(or_we), .idx(or_idx), .wr_data(cfg_wdata[N_TERM-1:0]),
      .rd_data(or_rd), .term_hit(term_hit),
      .pal_mode(pal_mode), .dout(dout)
   );

   always_comb begin
      if (and_sel)      cfg_rdata = DW'(and_rd);
      else if (or_sel)  cfg_rdata = DW'(or_rd);
      else              cfg_rdata = '0;
   end
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8,
   parameter bit PAL_EN = 1'b1,
   localparam int N_ROWS = N_TERM + N_OUT,
   localparam int AW     = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
   localparam int DW     = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [AW-1:0]    cfg_addr,
   input logic [DW-1:0]    cfg_wdata,
   input logic [DW-1:0]    cfg_rdata,
   input logic             pal_mode,
   input logic [N_IN-1:0]  din,
   input logic [N_OUT-1:0] dout
);
   localparam logic [AW:0]   A_TERM   = (AW+1)'(N_TERM);
   localparam logic [AW:0]   A_ROWS   = (AW+1)'(N_ROWS);
   localparam logic [DW-1:0] AND_MASK = (DW'(1) << (2 * N_IN)) - DW'(1);
   localparam logic [DW-1:0] OR_MASK  = (DW'(1) << N_TERM) - DW'(1);

   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cfg_addr} >= A_ROWS) |-> (cfg_rdata == '0));

   p_and_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && ({1'b0, $past(cfg_addr)} < A_TERM) && (cfg_addr == $past(cfg_addr)))
      |-> (cfg_rdata == ($past(cfg_wdata) & AND_MASK)));

   p_or_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_we) && ({1'b0, $past(cfg_addr)} >= A_TERM) &&
       ({1'b0, $past(cfg_addr)} < A_ROWS) && (cfg_addr == $past(cfg_addr)))
      |-> (cfg_rdata == ($past(cfg_wdata) & OR_MASK)));

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(cfg_addr)) |-> $stable(cfg_rdata));

   p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(din) && $stable(pal_mode)) |-> $stable(dout));

   generate
      if (PAL_EN) begin : g_pal_chk
         p_fixed_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pal_mode && $past(pal_mode) && $stable(din) &&
             !($past(cfg_we) && ({1'b0, $past(cfg_addr)} < A_TERM)))
            |-> $stable(dout));
      end
   endgenerate
endmodule

bind pla_core pla_core_chk #(
   .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_EN(PAL_EN)
) u_chk (.*);

// File: tb/pla_core_bench.sv
`timescale 1ns/1ps
module pla_core_bench;
   localparam int NI = 16, NT = 48, NO = 8, GRP = 6;

   logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, pal_mode = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [47:0] cfg_wdata = '0;
   logic [15:0] din = '0;
   logic [47:0] cfg_rdata;
   logic [7:0]  dout;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] and_sh [NT];
   logic [47:0] or_sh [NO];

   always #2 clk = ~clk;

   pla_core u_pla_core (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pal_mode(pal_mode),
      .din(din), .dout(dout)
   );

   function automatic logic term_val(int t, logic [15:0] x);
      logic v = 1'b1;
      for (int i = 0; i < NI; i++) begin
         case (and_sh[t][2*i +: 2])
            2'b01:   if (!x[i]) v = 1'b0;
            2'b10:   if (x[i])  v = 1'b0;
            2'b11:   v = 1'b0;
            default: ;
         endcase
      end
      return v;
   endfunction

   function automatic logic [7:0] model(logic [15:0] x, logic pal);
      logic [7:0] y = '0;
      for (int k = 0; k < NO; k++)
         for (int t = 0; t < NT; t++)
            if (pal ? (t / GRP == k) : or_sh[k][t])
               if (term_val(t, x)) y[k] = 1'b1;
      return y;
   endfunction

   function automatic logic [31:0] rnd_row();
      logic [31:0] r = '0;
      for (int i = 0; i < NI; i++) begin
         int u = int'($urandom % 16);
         if (u < 2)       r[2*i +: 2] = 2'b01;
         else if (u < 4)  r[2*i +: 2] = 2'b10;
         else if (u == 4 && ($urandom % 4 == 0)) r[2*i +: 2] = 2'b11;
      end
      return r;
   endfunction

   function automatic logic [31:0] row4(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d);
      return {24'h0, d, c, b, a};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(logic [5:0] a, logic [47:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < NT)           and_sh[a] = d[31:0];
      else if (a < NT + NO) or_sh[a - NT] = d;
   endtask

   task automatic read_chk(string req, logic [5:0] a, logic [47:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1 chk(req, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic drive_chk(string req, logic [15:0] x, logic pal);
      @(negedge clk);
      din = x; pal_mode = pal;
      #1 chk(req, 64'(dout), 64'(model(x, pal)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic a, b, c, d;
      logic [7:0] held;
      void'($urandom(32'd20240611));
      for (int t = 0; t < NT; t++) and_sh[t] = '0;
      for (int k = 0; k < NO; k++) or_sh[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state, R5 empty terms and outputs
      read_chk("R1 and row 0", 6'd0, '0);
      read_chk("R1 and row 47", 6'd47, '0);
      read_chk("R1 or row 0", 6'd48, '0);
      read_chk("R1 or row 7", 6'd55, '0);
      drive_chk("R1 R5 empty outputs", 16'hA5C3, 1'b0);
      @(negedge clk); pal_mode = 1'b1;
      #1 chk("R5 R7 empty terms all true", 64'(dout), 64'hFF);

      // R10 shared-term example
      cfg_write(6'd0, 48'(row4(2'b10, 2'b01, 2'b00, 2'b01)));
      cfg_write(6'd1, 48'(row4(2'b01, 2'b01, 2'b00, 2'b01)));
      cfg_write(6'd2, 48'(row4(2'b01, 2'b10, 2'b10, 2'b00)));
      cfg_write(6'd3, 48'(row4(2'b00, 2'b10, 2'b01, 2'b00)));
      cfg_write(6'd4, 48'(row4(2'b00, 2'b00, 2'b01, 2'b00)));
      cfg_write(6'd5, 48'(row4(2'b00, 2'b01, 2'b01, 2'b00)));
      for (int t = 6; t < NT; t++) cfg_write(6'(t), 48'h1);
      cfg_write(6'd48, 48'b001111);
      cfg_write(6'd49, 48'b010001);
      cfg_write(6'd50, 48'b100110);
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         pal_mode = 1'b0;
         din = {12'($urandom), 4'(v)};
         {d, c, b, a} = 4'(v);
         #1;
         chk("R10 f1", 64'(dout[0]), 64'((!a&b&d)|(a&b&d)|(a&!b&!c)|(!b&c)));
         chk("R10 f2", 64'(dout[1]), 64'(c|(!a&b&d)));
         chk("R10 f3", 64'(dout[2]), 64'((b&c)|(a&!b&!c)|(a&b&d)));
         chk("R5 R6 unused outputs", 64'(dout[7:3]), 64'h0);
      end

      // R4 forcing code, R5 empty term
      cfg_write(6'd10, 48'h3 << 10);
      cfg_write(6'd11, 48'h0);
      cfg_write(6'd53, 48'h1 << 10);
      cfg_write(6'd54, 48'h1 << 11);
      for (int n = 0; n < 8; n++) begin
         drive_chk("R4 R9 forced term", 16'($urandom), 1'b0);
         chk("R4 forced term gives 0", 64'(dout[5]), 64'h0);
         chk("R5 empty term gives 1", 64'(dout[6]), 64'h1);
      end

      // R8 unmapped address write and readback
      cfg_write(6'd58, {48{1'b1}});
      read_chk("R8 unmapped read", 6'd58, '0);
      read_chk("R8 and row kept", 6'd10, 48'(and_sh[10]));
      read_chk("R8 or row kept", 6'd50, or_sh[2]);
      drive_chk("R8 outputs unchanged", 16'h0006, 1'b0);

      // R2 R3 R6 R7 R9 random planes in both modes
      for (int round = 0; round < 12; round++) begin
         for (int t = 0; t < NT; t++) cfg_write(6'(t), {16'($urandom), rnd_row()});
         for (int k = 0; k < NO; k++) cfg_write(6'(NT + k), {16'($urandom), 32'($urandom)});
         for (int t = 0; t < NT; t++) read_chk("R2 and readback", 6'(t), 48'(and_sh[t]));
         for (int k = 0; k < NO; k++) read_chk("R3 or readback", 6'(NT + k), or_sh[k]);
         read_chk("R8 unmapped read", 6'(56 + ($urandom % 8)), '0);
         for (int n = 0; n < 24; n++) begin
            drive_chk("R6 R9 shared mode", 16'($urandom), 1'b0);
            drive_chk("R7 R9 fixed mode", 16'($urandom), 1'b1);
         end
         // R7 OR-row write ignored in fixed mode
         @(negedge clk); held = dout;
         cfg_write(6'(NT + ($urandom % NO)), ~{16'($urandom), 32'($urandom)});
         #1 chk("R7 or write ignored", 64'(dout), 64'(held));
         chk("R7 fixed mode model", 64'(dout), 64'(model(din, 1'b1)));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule